// File: doc/BRIEF.md
# Translation Unit Control and Interrupt Register Block

This block is the software-facing control plane of an address translation unit. A processor reaches it over a simple 32-bit register bus. Through that bus it programs the base address of the first-level translation table, issues commands, reads a status word, and services the unit's interrupts. The table walker and the translation cache sit outside the block. This block drives their control inputs: translation enable, a stall request, a hold-off while a fault is outstanding, and invalidate strobes. It also takes in their fault and bus-error events.

Commands go through a small state machine that tracks whether translation is on and whether the unit is stalled. A stall can only be entered while translation is on. When a page fault arrives, its virtual address and direction are captured, and further translation is held off until software acknowledges the fault. A forced-reset command returns every stored register to zero in one cycle.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset, every stored register reads zero, the interrupt output is low, and the status word reads 0x8000_0000 when the idle and replay-empty inputs are low.
- R2: The table-base register (word 0x00) stores only bits 31:12, and its low 12 bits read as zero: writing 0xCAFEBABE reads back 0xCAFEB000. The stored value is presented on `tbl_base`.
- R3: Writing value 0 to the command register (word 0x08) turns translation on, and value 1 turns it off. Status bit 0 and `wk_xlat_en` follow.
- R4: Command 2 enters stall only while translation is on, and is ignored otherwise. Command 3 leaves stall and returns the unit to its prior translation state. Status bit 2 shows that stall is active, and bit 31 is its complement.
- R5: Command 4 produces a one-cycle `inv_all` pulse. A write to word 0x10 produces a one-cycle `inv_one` pulse, with the written value on `inv_one_addr`.
- R6: A fault event that arrives while no fault is outstanding does four things: it latches the virtual address into word 0x0C, latches the write flag into status bit 5, sets status bit 1, and sets raw interrupt bit 0. A fault event that arrives while a fault is outstanding changes neither the address nor the flag. Command 5 clears status bit 1.
- R7: A bus-error event sets raw interrupt bit 1 (word 0x14).
- R8: The interrupt mask (word 0x1C) keeps bits 1:0. The masked status (word 0x20) equals raw AND mask, and `irq` is the OR of the masked bits in the same cycle.
- R9: Writing ones to the clear register (word 0x18) clears those raw bits. An event in the same cycle as its clear leaves the bit set.
- R10: Command 6 clears the table base, the fault address, the fault flags, raw interrupts, the mask, the gating register and the mode state.
- R11: `wk_hold` is high whenever stall is active or a fault is outstanding.
- R12: The following accesses are ignored: writes to status, fault address, masked status and unmapped words; command values 7 and above; and any access whose address bits 1:0 are not zero. Such reads return zero. Word 0x24 is plain 32-bit read/write storage.
- R13: Status bits 3 and 4 show the walker's idle and replay-empty inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| wk_idle | input | 1 | Walker reports idle |
| wk_replay_empty | input | 1 | Walker replay buffer empty |
| wk_fault | input | 1 | Page fault event pulse |
| wk_fault_va | input | DATA_W | Faulting virtual address |
| wk_fault_wr | input | 1 | Faulting access was a write |
| wk_bus_err | input | 1 | Bus read error event pulse |
| wk_xlat_en | output | 1 | Translation enabled |
| wk_stall | output | 1 | Stall active |
| wk_hold | output | 1 | Hold off new translations |
| tbl_base | output | DATA_W | First-level table base address |
| inv_one | output | 1 | Single-entry invalidate strobe |
| inv_one_addr | output | DATA_W | Address for the single-entry invalidate |
| inv_all | output | 1 | Whole-cache invalidate strobe |
| irq | output | 1 | Interrupt request |

## Verification
A write or command is sampled on one clock edge. Its effect on mode, stored registers, `wk_hold`, `irq` and the invalidate strobes appears right after that edge and can be seen at the next falling edge. A read is also sampled on one edge, and its data is on `bus_rdata` right after it. The bench drives every access from a falling edge and compares at the following falling edge. Expected read values pass through a queue, and a monitor pops them exactly one edge after it sees the read. Strobes are checked at that same falling edge and again one cycle later, to confirm that they last a single cycle.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
  // word indices (byte offset / 4)
  localparam int IDX_TBL   = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_CMD   = 2;
  localparam int IDX_FVA   = 3;
  localparam int IDX_INV1  = 4;
  localparam int IDX_RAW   = 5;
  localparam int IDX_CLR   = 6;
  localparam int IDX_MASK  = 7;
  localparam int IDX_MSTAT = 8;
  localparam int IDX_GATE  = 9;

  // command codes
  localparam logic [2:0] CMD_XLAT_ON   = 3'd0;
  localparam logic [2:0] CMD_XLAT_OFF  = 3'd1;
  localparam logic [2:0] CMD_STALL_ON  = 3'd2;
  localparam logic [2:0] CMD_STALL_OFF = 3'd3;
  localparam logic [2:0] CMD_INV_ALL   = 3'd4;
  localparam logic [2:0] CMD_FAULT_ACK = 3'd5;
  localparam logic [2:0] CMD_WIPE      = 3'd6;
  localparam int         CMD_LIMIT     = 7;

  // status bit positions
  localparam int ST_XLAT    = 0;
  localparam int ST_FAULT   = 1;
  localparam int ST_STALL   = 2;
  localparam int ST_IDLE    = 3;
  localparam int ST_REPLAY  = 4;
  localparam int ST_FWRITE  = 5;
  localparam int ST_NOSTALL = 31;

  // interrupt bit positions
  localparam int IRQ_FAULT  = 0;
  localparam int IRQ_BUSERR = 1;

  typedef enum logic [1:0] {
    M_OFF      = 2'd0,
    M_RUN      = 2'd1,
    M_HALT_RUN = 2'd2,
    M_HALT_OFF = 2'd3
  } mode_e;
endpackage

// File: rtl/xlat_mode_fsm.sv
module xlat_mode_fsm
  import xlat_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wipe,
  input  logic       cmd_vld,
  input  logic [2:0] cmd_code,
  output logic       xlat_on,
  output logic       stall_on
);
  mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cmd_vld) begin
      unique case (state_q)
        M_OFF: begin
          if (cmd_code == CMD_XLAT_ON) state_d = M_RUN;
        end
        M_RUN: begin
          if (cmd_code == CMD_XLAT_OFF)      state_d = M_OFF;
          else if (cmd_code == CMD_STALL_ON) state_d = M_HALT_RUN;
        end
        M_HALT_RUN: begin
          if (cmd_code == CMD_STALL_OFF)     state_d = M_RUN;
          else if (cmd_code == CMD_XLAT_OFF) state_d = M_HALT_OFF;
        end
        M_HALT_OFF: begin
          if (cmd_code == CMD_STALL_OFF)     state_d = M_OFF;
          else if (cmd_code == CMD_XLAT_ON)  state_d = M_HALT_RUN;
        end
        default: state_d = M_OFF;
      endcase
    end
    if (wipe) state_d = M_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= M_OFF;
    else     state_q <= state_d;
  end

  assign xlat_on  = (state_q == M_RUN) || (state_q == M_HALT_RUN);
  assign stall_on = (state_q == M_HALT_RUN) || (state_q == M_HALT_OFF);
endmodule

// File: rtl/xlat_fault_cap.sv
module xlat_fault_cap #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wipe,
  input  logic            ack,
  input  logic            ev_fault,
  input  logic [VA_W-1:0] ev_va,
  input  logic            ev_wr,
  output logic            accept,
  output logic            active,
  output logic [VA_W-1:0] va_q,
  output logic            wr_q
);
  // only the first fault is captured until software acknowledges it
  assign accept = ev_fault & ~active;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      active <= 1'b0;
      va_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      if (accept) begin
        active <= 1'b1;
        va_q   <= ev_va;
        wr_q   <= ev_wr;
      end else if (ack) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlat_irq_unit.sv
module xlat_irq_unit #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic [N-1:0] set_ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] raw,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] raw_d;
  logic [N-1:0] mask_d;

  // event beats clear on the same bit
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign raw_d[i] = set_ev[i] | (raw[i] & ~(clr_we & clr_bits[i]));
  end

  assign mask_d = mask_we ? mask_bits : mask;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      raw  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      raw  <= raw_d;
      mask <= mask_d;
      irq  <= |(raw_d & mask_d);
    end
  end

  assign masked = raw & mask;
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xlat_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BASE_LSB = 12,
  parameter int IRQ_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wk_idle,
  input  logic              wk_replay_empty,
  input  logic              wk_fault,
  input  logic [DATA_W-1:0] wk_fault_va,
  input  logic              wk_fault_wr,
  input  logic              wk_bus_err,
  output logic              wk_xlat_en,
  output logic              wk_stall,
  output logic              wk_hold,
  output logic [DATA_W-1:0] tbl_base,
  output logic              inv_one,
  output logic [DATA_W-1:0] inv_one_addr,
  output logic              inv_all,
  output logic              irq
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int BASE_W = DATA_W - BASE_LSB;

  // ---------------- decode ----------------
  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic              wr_hit, rd_hit;
  logic              cmd_vld;
  logic [2:0]        cmd_code;
  logic              wipe, fault_ack;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign idx      = bus_addr[ADDR_W-1:2];
  assign wr_hit   = bus_sel & bus_we & aligned;
  assign rd_hit   = bus_sel & ~bus_we & aligned;
  assign cmd_vld  = wr_hit && (idx == IDX_W'(IDX_CMD)) && (bus_wdata < DATA_W'(CMD_LIMIT));
  assign cmd_code = bus_wdata[2:0];
  assign wipe      = cmd_vld && (cmd_code == CMD_WIPE);
  assign fault_ack = cmd_vld && (cmd_code == CMD_FAULT_ACK);

  // ---------------- mode machine ----------------
  logic xlat_on, stall_on;

  xlat_mode_fsm u_mode (
    .clk      (clk),
    .rst      (rst),
    .wipe     (wipe),
    .cmd_vld  (cmd_vld),
    .cmd_code (cmd_code),
    .xlat_on  (xlat_on),
    .stall_on (stall_on)
  );

  // ---------------- fault capture ----------------
  logic              f_accept, f_active, f_wr;
  logic [DATA_W-1:0] f_va;

  xlat_fault_cap #(.VA_W(DATA_W)) u_fault (
    .clk      (clk),
    .rst      (rst),
    .wipe     (wipe),
    .ack      (fault_ack),
    .ev_fault (wk_fault),
    .ev_va    (wk_fault_va),
    .ev_wr    (wk_fault_wr),
    .accept   (f_accept),
    .active   (f_active),
    .va_q     (f_va),
    .wr_q     (f_wr)
  );

  // ---------------- interrupts ----------------
  logic [IRQ_N-1:0] set_ev, raw, mask, masked;

  always_comb begin
    set_ev             = '0;
    set_ev[IRQ_FAULT]  = f_accept;
    set_ev[IRQ_BUSERR] = wk_bus_err;
  end

  xlat_irq_unit #(.N(IRQ_N)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .wipe      (wipe),
    .set_ev    (set_ev),
    .clr_we    (wr_hit && (idx == IDX_W'(IDX_CLR))),
    .clr_bits  (bus_wdata[IRQ_N-1:0]),
    .mask_we   (wr_hit && (idx == IDX_W'(IDX_MASK))),
    .mask_bits (bus_wdata[IRQ_N-1:0]),
    .raw       (raw),
    .mask      (mask),
    .masked    (masked),
    .irq       (irq)
  );

  // ---------------- stored registers ----------------
  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] gate_q;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      base_q <= '0;
      gate_q <= '0;
    end else if (wr_hit) begin
      if (idx == IDX_W'(IDX_TBL))  base_q <= bus_wdata[DATA_W-1:BASE_LSB];
      if (idx == IDX_W'(IDX_GATE)) gate_q <= bus_wdata;
    end
  end

  assign tbl_base = {base_q, {BASE_LSB{1'b0}}};

  // ---------------- invalidate strobes ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_all      <= 1'b0;
      inv_one      <= 1'b0;
      inv_one_addr <= '0;
    end else begin
      inv_all <= cmd_vld && (cmd_code == CMD_INV_ALL);
      inv_one <= wr_hit && (idx == IDX_W'(IDX_INV1));
      if (wr_hit && (idx == IDX_W'(IDX_INV1))) inv_one_addr <= bus_wdata;
    end
  end

  // ---------------- status and read path ----------------
  logic [DATA_W-1:0] status;

  always_comb begin
    status             = '0;
    status[ST_XLAT]    = xlat_on;
    status[ST_FAULT]   = f_active;
    status[ST_STALL]   = stall_on;
    status[ST_IDLE]    = wk_idle;
    status[ST_REPLAY]  = wk_replay_empty;
    status[ST_FWRITE]  = f_wr;
    status[ST_NOSTALL] = ~stall_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      case (idx)
        IDX_W'(IDX_TBL):   bus_rdata <= tbl_base;
        IDX_W'(IDX_STAT):  bus_rdata <= status;
        IDX_W'(IDX_FVA):   bus_rdata <= f_va;
        IDX_W'(IDX_RAW):   bus_rdata <= DATA_W'(raw);
        IDX_W'(IDX_MASK):  bus_rdata <= DATA_W'(mask);
        IDX_W'(IDX_MSTAT): bus_rdata <= DATA_W'(masked);
        IDX_W'(IDX_GATE):  bus_rdata <= gate_q;
        default:           bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  assign wk_xlat_en = xlat_on;
  assign wk_stall   = stall_on;
  assign wk_hold    = stall_on | f_active;
endmodule

// File: rtl/xlat_ctrl_regs_chk.sv
module xlat_ctrl_regs_chk
  import xlat_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BASE_LSB = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wk_fault,
  input logic              wk_xlat_en,
  input logic              wk_stall,
  input logic              wk_hold,
  input logic [DATA_W-1:0] tbl_base,
  input logic              inv_one,
  input logic              inv_all,
  input logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] c_idx;
  logic c_al, c_wr, c_rd, c_cmd;
  assign c_idx = bus_addr[ADDR_W-1:2];
  assign c_al  = (bus_addr[1:0] == 2'b00);
  assign c_wr  = bus_sel & bus_we & c_al;
  assign c_rd  = bus_sel & ~bus_we & c_al;
  assign c_cmd = c_wr && (c_idx == IDX_W'(IDX_CMD));

  assert_base_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (c_wr && c_idx == IDX_W'(IDX_TBL)) |=>
      (tbl_base[DATA_W-1:BASE_LSB] == $past(bus_wdata[DATA_W-1:BASE_LSB])));

  assert_stall_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wk_stall) |-> $past(wk_xlat_en));

  assert_inv_all_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !inv_all);

  assert_inv_one_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    inv_one |=> !inv_one);

  assert_fault_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (wk_fault && !c_cmd) |=> wk_hold);

  assert_wipe_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (c_cmd && bus_wdata == DATA_W'(CMD_WIPE)) |=>
      (tbl_base == '0 && !wk_xlat_en && !wk_stall && !irq));

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (rst)
    wk_stall |-> wk_hold);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_idx > IDX_W'(IDX_GATE)) |=> (bus_rdata == '0));
endmodule

bind xlat_ctrl_regs xlat_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_LSB(BASE_LSB)
) u_chk (.*);

// File: tb/xlat_ctrl_regs_bench.sv
module xlat_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wk_idle = 1'b0, wk_replay_empty = 1'b0;
  logic        wk_fault = 1'b0, wk_fault_wr = 1'b0, wk_bus_err = 1'b0;
  logic [31:0] wk_fault_va = '0;
  logic        wk_xlat_en, wk_stall, wk_hold, inv_one, inv_all, irq;
  logic [31:0] tbl_base, inv_one_addr;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  xlat_ctrl_regs u_xlat_ctrl_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wk_idle(wk_idle), .wk_replay_empty(wk_replay_empty),
    .wk_fault(wk_fault), .wk_fault_va(wk_fault_va), .wk_fault_wr(wk_fault_wr),
    .wk_bus_err(wk_bus_err), .wk_xlat_en(wk_xlat_en), .wk_stall(wk_stall),
    .wk_hold(wk_hold), .tbl_base(tbl_base), .inv_one(inv_one),
    .inv_one_addr(inv_one_addr), .inv_all(inv_all), .irq(irq)
  );

  localparam logic [7:0] A_TBL = 8'h00, A_STAT = 8'h04, A_CMD = 8'h08,
    A_FVA = 8'h0C, A_INV1 = 8'h10, A_RAW = 8'h14, A_CLR = 8'h18,
    A_MASK = 8'h1C, A_MSTAT = 8'h20, A_GATE = 8'h24;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic fault(input logic [31:0] va, input logic w);
    @(negedge clk);
    wk_fault = 1'b1; wk_fault_va = va; wk_fault_wr = w;
    @(negedge clk);
    wk_fault = 1'b0;
  endtask

  task automatic buserr();
    @(negedge clk);
    wk_bus_err = 1'b1;
    @(negedge clk);
    wk_bus_err = 1'b0;
  endtask

  // monitor: read data is due one edge after the read is sampled
  always begin
    @(posedge clk);
    if (bus_sel && !bus_we) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_STAT, 32'h8000_0000, "R1 status");
    rd(A_TBL, 32'h0, "R1 base");
    rd(A_MASK, 32'h0, "R1 mask");
    rd(A_RAW, 32'h0, "R1 raw");
    chk({31'b0, irq}, 32'h0, "R1 irq");

    // R2 base alignment
    wr(A_TBL, 32'hCAFE_BABE);
    rd(A_TBL, 32'hCAFE_B000, "R2 base readback");
    chk(tbl_base, 32'hCAFE_B000, "R2 base port");

    // R3 / R4 / R11 mode commands
    wr(A_CMD, 32'd2);
    rd(A_STAT, 32'h8000_0000, "R4 stall ignored while off");
    wr(A_CMD, 32'd0);
    rd(A_STAT, 32'h8000_0001, "R3 enable");
    chk({31'b0, wk_xlat_en}, 32'h1, "R3 enable port");
    wr(A_CMD, 32'd2);
    rd(A_STAT, 32'h0000_0005, "R4 stall on");
    chk({30'b0, wk_stall, wk_hold}, 32'h3, "R11 hold in stall");
    wr(A_CMD, 32'd3);
    rd(A_STAT, 32'h8000_0001, "R4 stall off");
    chk({31'b0, wk_hold}, 32'h0, "R11 hold released");
    wr(A_CMD, 32'd1);
    rd(A_STAT, 32'h8000_0000, "R3 disable");

    // R5 strobes
    wr(A_CMD, 32'd4);
    chk({31'b0, inv_all}, 32'h1, "R5 inv_all high");
    @(negedge clk);
    chk({31'b0, inv_all}, 32'h0, "R5 inv_all one cycle");
    wr(A_INV1, 32'h1234_5000);
    chk({31'b0, inv_one}, 32'h1, "R5 inv_one high");
    chk(inv_one_addr, 32'h1234_5000, "R5 inv_one addr");
    @(negedge clk);
    chk({30'b0, inv_one, inv_all}, 32'h0, "R5 inv_one one cycle");

    // R6 / R8 fault capture
    wr(A_MASK, 32'h3);
    fault(32'hDEAD_1000, 1'b1);
    chk({30'b0, irq, wk_hold}, 32'h3, "R8 irq and R11 hold on fault");
    rd(A_STAT, 32'h8000_0022, "R6 status on fault");
    rd(A_FVA, 32'hDEAD_1000, "R6 fault address");
    rd(A_RAW, 32'h1, "R6 raw bit");
    rd(A_MSTAT, 32'h1, "R8 masked");
    fault(32'h1111_0000, 1'b0);
    rd(A_FVA, 32'hDEAD_1000, "R6 second fault ignored");
    rd(A_STAT, 32'h8000_0022, "R6 flag kept");
    wr(A_CMD, 32'd5);
    rd(A_STAT, 32'h8000_0020, "R6 fault done");
    chk({31'b0, wk_hold}, 32'h0, "R11 hold after ack");

    // R7 / R8 / R9 interrupts
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'h0, "R9 clear");
    chk({31'b0, irq}, 32'h0, "R9 irq low");
    buserr();
    chk({31'b0, irq}, 32'h1, "R7 irq");
    rd(A_RAW, 32'h2, "R7 bus error raw");
    wr(A_MASK, 32'h1);
    rd(A_MSTAT, 32'h0, "R8 masked off");
    chk({31'b0, irq}, 32'h0, "R8 irq masked");
    wr(A_MASK, 32'h3);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h2; wk_bus_err = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; wk_bus_err = 1'b0;
    rd(A_RAW, 32'h2, "R9 event beats clear");
    wr(A_CLR, 32'h3);
    rd(A_RAW, 32'h0, "R9 clear all");

    // R12 ignored accesses and gating storage
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h8000_0020, "R12 status write ignored");
    wr(A_FVA, 32'h0);
    rd(A_FVA, 32'hDEAD_1000, "R12 fault address write ignored");
    rd(8'h28, 32'h0, "R12 unmapped 0x28");
    rd(8'hFC, 32'h0, "R12 unmapped 0xFC");
    wr(A_GATE, 32'hA5A5_1234);
    rd(A_GATE, 32'hA5A5_1234, "R12 gating storage");
    wr(A_CMD, 32'd7);
    wr(A_CMD, 32'h100);
    rd(A_STAT, 32'h8000_0020, "R12 out-of-range commands");
    wr(8'h01, 32'hFFFF_F000);
    rd(A_TBL, 32'hCAFE_B000, "R12 misaligned write ignored");
    rd(8'h02, 32'h0, "R12 misaligned read zero");

    // R13 walker status inputs
    wk_idle = 1'b1; wk_replay_empty = 1'b1;
    rd(A_STAT, 32'h8000_0038, "R13 idle and replay");
    wk_idle = 1'b0; wk_replay_empty = 1'b0;

    // R10 forced reset
    wr(A_CMD, 32'd0);
    buserr();
    wr(A_CMD, 32'd2);
    wr(A_CMD, 32'd6);
    chk({29'b0, irq, wk_xlat_en, wk_stall}, 32'h0, "R10 outputs cleared");
    chk(tbl_base, 32'h0, "R10 base port");
    rd(A_TBL, 32'h0, "R10 base");
    rd(A_MASK, 32'h0, "R10 mask");
    rd(A_RAW, 32'h0, "R10 raw");
    rd(A_FVA, 32'h0, "R10 fault address");
    rd(A_GATE, 32'h0, "R10 gating");
    rd(A_STAT, 32'h8000_0000, "R10 status");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule